// File: doc/BRIEF.md
# Multi-Lane Serial Slave Transfer Engine

This block is the slave side of a serial link whose clock comes from an external master. While the master holds the active-low select input low, the engine moves one frame per programmed number of master clock cycles. Each cycle carries one, two or four bits, according to a lane setting. It receives and transmits at the same time: the bits shifted out come from a transmit holding register, and the bits shifted in collect into a word that goes to a receive register when the frame ends.

All master-side inputs (clock, select and the four data lines) cross into the system clock domain through two-flop synchronizers. Edges are detected there, so the system clock must run at least four times faster than the master clock. The host side has a transmit write strobe, a receive read strobe, three write-one-to-clear flags, and one interrupt line for each flag. The frame length and lane setting must stay constant while a frame is in progress.

If software supplies no new transmit word, the shift register keeps the bits it last received and sends them out again in the next frame. If the master releases select in the middle of a frame, the partial frame is dropped and nothing is reported.

Top module: `lsx_slave`

## Requirements
- R1: While select is high, master clock edges and data-line values do not change the shift register, the bit count or the flags, and `tx_wr` is ignored.
- R2: Releasing select after at least one clock cycle of a frame, and before the frame's last cycle, clears the bit count and zeroes the shift register. No receive flag is set.
- R3: A frame starts only on a rising master clock edge while select is low. A transmit write never starts a frame, and a frame runs with no prior transmit write.
- R4: `cfg_cycles` holds the number of clock cycles per frame minus one (0 means 1 cycle, 15 means 16 cycles). `cfg_lanes` sets the bits per cycle: 0 means 1, 1 means 2, and 2 or 3 mean 4. A frame holds cycles × lanes bits, right-aligned in the data words.
- R5: `flags[0]` (transmit empty) is 1 after reset. It is set when the transmit word moves into the idle shift register, and it is cleared by an accepted `tx_wr`.
- R6: Data goes out most significant bit first. Within a cycle, the highest active lane carries the most significant bit. Outputs change only while the master clock is low, and inputs are taken at its rising edge.
- R7: At the end of a frame the received word is written to `rx_data` and `flags[1]` (receive full) is set. A `rx_rd` pulse clears it.
- R8: If a frame ends while `flags[1]` is set, `rx_data` is overwritten with the new word and `flags[2]` (overrun) is set.
- R9: If no transmit word is waiting when the next frame starts, that frame sends out the word received in the previous frame, unchanged.
- R10: Writing 1 to a bit of `flag_clr` clears that flag. Each `irq` bit is the AND of its flag and the matching `irq_en` bit.
- R11: `m_dio_oe` enables exactly the active lanes while select is low, and is all zero while select is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| m_sclk | input | 1 | Master serial clock (idle low) |
| m_sel_n | input | 1 | Active-low select from master |
| m_dio_in | input | 4 | Data lines from master |
| m_dio_out | output | 4 | Data lines toward master |
| m_dio_oe | output | 4 | Per-lane output enable |
| cfg_cycles | input | 4 | Clock cycles per frame minus one |
| cfg_lanes | input | 2 | Lane width code |
| irq_en | input | 3 | Interrupt enables {overrun, rx full, tx empty} |
| tx_wr | input | 1 | Transmit word write strobe |
| tx_wdata | input | 64 | Transmit word, right-aligned |
| rx_rd | input | 1 | Receive word read strobe |
| flag_clr | input | 3 | Write-one-to-clear for flags |
| rx_data | output | 64 | Last received word, right-aligned |
| flags | output | 3 | {overrun, rx full, tx empty} |
| irq | output | 3 | Interrupt outputs, same order as flags |

## Verification
Frames run at all three lane widths and at 5, 8 and 16 cycles, each with distinct transmit and receive words, so a wrong lane mapping, a bit-order error or a wrong frame length shows up as a mismatched word in one direction or the other. A transmit write in the middle of a frame separates a correct buffer handover from an early load. Frames with no new write separate recirculation from stale or zeroed output. One frame follows an aborted one, and another follows clock and write activity while deselected: the first tells discard apart from keeping the partial data, and the second tells true ignoring apart from partial capture. Two frames with no read in between expose overrun handling.

// File: rtl/lsx_pkg.sv
// Package: shared sizing and lane decode for the serial slave engine.
// Assumes at most four data lanes and a 4-bit frame-cycle field.
package lsx_pkg;
    localparam int CYC_W    = 4;
    localparam int LANES    = 4;
    localparam int WORD_W   = (1 << CYC_W) * LANES;
    localparam int FB_W     = $clog2(WORD_W + 1);

    typedef logic [WORD_W-1:0] word_t;

    typedef enum logic [1:0] {
        LW_ONE  = 2'd0,
        LW_TWO  = 2'd1,
        LW_FOUR = 2'd2,
        LW_ALT4 = 2'd3
    } lane_mode_e;

    // Number of bits moved per master clock cycle for a lane code.
    function automatic logic [2:0] lanes_of(input logic [1:0] code);
        case (lane_mode_e'(code))
            LW_ONE:  return 3'd1;
            LW_TWO:  return 3'd2;
            default: return 3'd4;
        endcase
    endfunction
endpackage

// File: rtl/lsx_sync.sv
// Two-flop synchronizer for a bundle of asynchronous inputs.
// Assumes each bit is independently meaningful after two flops
// and that the source is slow relative to clk.
module lsx_sync #(
    parameter int             W       = 1,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;
    logic [W-1:0] stage2;

    // Two-stage capture into the clk domain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1 <= RST_VAL;
            stage2 <= RST_VAL;
        end else begin
            stage1 <= d;
            stage2 <= stage1;
        end
    end

    assign q = stage2;
endmodule

// File: rtl/lsx_shifter.sv
// Frame shifter: edge detection on the synchronized master clock and
// select, the bit counter, the shared shift register and the lane outputs.
// Assumes clk is at least 4x the master clock and that cfg is held
// constant during a frame. Mode 0: sample on rise, drive while low.
module lsx_shifter
    import lsx_pkg::*;
#(
    parameter int CW  = CYC_W,
    parameter int NL  = LANES,
    parameter int WW  = WORD_W,
    parameter int FBW = FB_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sclk_s,
    input  logic          sel_n_s,
    input  logic [NL-1:0] din_s,
    input  logic [CW-1:0] cyc_cfg,
    input  logic [1:0]    lane_cfg,
    input  logic [WW-1:0] tx_word,
    input  logic          tx_full,
    output logic          tx_take,
    output logic          frame_done,
    output logic [WW-1:0] rx_word,
    output logic          sel,
    output logic [NL-1:0] dout,
    output logic [NL-1:0] doe
);
    logic          sclk_q;
    logic          sel_n_q;
    logic          rise;
    logic          abort;
    logic [CW-1:0] bit_cnt;
    logic [WW-1:0] sreg;
    logic [NL-1:0] dout_q;
    logic [2:0]    n_lanes;
    logic [NL-1:0] lane_mask;
    logic [NL-1:0] lane_val;
    logic [FBW-1:0] frame_bits;
    logic [WW-1:0] frame_mask;
    logic [WW-1:0] top_bits;
    logic [WW-1:0] in_word;
    logic [WW-1:0] shifted;
    logic          last_cycle;

    assign sel        = !sel_n_s;
    assign rise       = sel && sclk_s && !sclk_q;
    assign abort      = sel_n_s && !sel_n_q;
    assign n_lanes    = lanes_of(lane_cfg);
    assign lane_mask  = NL'((32'd1 << n_lanes) - 32'd1);
    assign frame_bits = FBW'((32'(cyc_cfg) + 32'd1) * 32'(n_lanes));
    assign frame_mask = (32'(frame_bits) >= WW) ? '1
                      : ((WW'(1) << frame_bits) - WW'(1));
    assign top_bits   = sreg >> (frame_bits - FBW'(n_lanes));
    assign in_word    = WW'(din_s & lane_mask);
    assign shifted    = ((sreg << n_lanes) | in_word) & frame_mask;
    assign last_cycle = (bit_cnt == cyc_cfg);
    assign tx_take    = sel && !rise && (bit_cnt == '0) && tx_full;
    assign rx_word    = sreg;

    // Remember previous synchronized clock and select for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_q  <= 1'b0;
            sel_n_q <= 1'b1;
        end else begin
            sclk_q  <= sclk_s;
            sel_n_q <= sel_n_s;
        end
    end

    // Counter and shift register: abort, shift on rise, or idle load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sreg       <= '0;
            bit_cnt    <= '0;
            frame_done <= 1'b0;
        end else begin
            frame_done <= 1'b0;
            if (abort) begin
                bit_cnt <= '0;
                if (bit_cnt != '0) sreg <= '0;
            end else if (rise) begin
                sreg <= shifted;
                if (last_cycle) begin
                    bit_cnt    <= '0;
                    frame_done <= 1'b1;
                end else begin
                    bit_cnt <= bit_cnt + 1'b1;
                end
            end else if (tx_take) begin
                sreg <= tx_word & frame_mask;
            end
        end
    end

    for (genvar k = 0; k < NL; k++) begin : g_lane
        assign lane_val[k] = lane_mask[k] & top_bits[k];
        assign doe[k]      = sel & lane_mask[k];
    end

    // Output lanes follow the shift register only while master clock is low.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dout_q <= '0;
        end else if (!sel) begin
            dout_q <= '0;
        end else if (!sclk_s) begin
            dout_q <= lane_val;
        end
    end

    assign dout = dout_q;

    assert_abort_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
        abort |=> (bit_cnt == '0) && !frame_done);

    assert_no_frame_deselected_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !sel |=> !frame_done);

    assert_out_held_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(sclk_s) && sclk_s && $past(sel)) |-> $stable(dout_q));
endmodule

// File: rtl/lsx_hostregs.sv
// Host-side registers: transmit holding word, receive word, the three
// sticky flags and the gated interrupt lines.
// Assumes frame_done and tx_take are single-cycle pulses from the shifter.
module lsx_hostregs #(
    parameter int WW = lsx_pkg::WORD_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sel,
    input  logic          tx_wr,
    input  logic [WW-1:0] tx_wdata,
    input  logic          rx_rd,
    input  logic [2:0]    flag_clr,
    input  logic [2:0]    irq_en,
    input  logic          tx_take,
    input  logic          frame_done,
    input  logic [WW-1:0] rx_word,
    output logic [WW-1:0] tx_word,
    output logic          tx_full,
    output logic [WW-1:0] rx_data,
    output logic [2:0]    flags,
    output logic [2:0]    irq
);
    logic wr_ok;
    logic tbe_flag;
    logic rbf_flag;
    logic ovr_flag;

    assign wr_ok = tx_wr && sel;

    // Transmit holding word: accepted writes fill it, loads empty it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_word <= '0;
            tx_full <= 1'b0;
        end else if (wr_ok) begin
            tx_word <= tx_wdata;
            tx_full <= 1'b1;
        end else if (tx_take) begin
            tx_full <= 1'b0;
        end
    end

    // Transmit-empty flag: set on load, cleared by write or write-one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tbe_flag <= 1'b1;
        end else if (wr_ok) begin
            tbe_flag <= 1'b0;
        end else if (tx_take) begin
            tbe_flag <= 1'b1;
        end else if (flag_clr[0]) begin
            tbe_flag <= 1'b0;
        end
    end

    // Receive word, receive-full and overrun flags; setting wins over clearing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_data  <= '0;
            rbf_flag <= 1'b0;
            ovr_flag <= 1'b0;
        end else begin
            if (frame_done) begin
                rx_data  <= rx_word;
                rbf_flag <= 1'b1;
            end else if (rx_rd || flag_clr[1]) begin
                rbf_flag <= 1'b0;
            end
            if (frame_done && rbf_flag) begin
                ovr_flag <= 1'b1;
            end else if (flag_clr[2]) begin
                ovr_flag <= 1'b0;
            end
        end
    end

    assign flags = {ovr_flag, rbf_flag, tbe_flag};
    assign irq   = flags & irq_en;

    assert_rbf_after_frame_R7: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |=> rbf_flag);

    assert_ovr_needs_full_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovr_flag) |-> $past(rbf_flag) && $past(frame_done));

    assert_tbe_on_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_take && !wr_ok) |=> tbe_flag);
endmodule

// File: rtl/lsx_slave.sv
// Top: serial slave transfer engine. Synchronizes master-side inputs,
// runs the frame shifter and exposes the host registers and interrupts.
// Assumes clk runs at least 4x the master clock; cfg stable within a frame.
module lsx_slave
    import lsx_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                m_sclk,
    input  logic                m_sel_n,
    input  logic [LANES-1:0]    m_dio_in,
    output logic [LANES-1:0]    m_dio_out,
    output logic [LANES-1:0]    m_dio_oe,
    input  logic [CYC_W-1:0]    cfg_cycles,
    input  logic [1:0]          cfg_lanes,
    input  logic [2:0]          irq_en,
    input  logic                tx_wr,
    input  logic [WORD_W-1:0]   tx_wdata,
    input  logic                rx_rd,
    input  logic [2:0]          flag_clr,
    output logic [WORD_W-1:0]   rx_data,
    output logic [2:0]          flags,
    output logic [2:0]          irq
);
    localparam int SYNC_W = LANES + 2;
    localparam logic [SYNC_W-1:0] SYNC_RST = SYNC_W'(1) << LANES;

    logic [SYNC_W-1:0] raw_in;
    logic [SYNC_W-1:0] synced;
    logic              sclk_s;
    logic              sel_n_s;
    logic [LANES-1:0]  din_s;
    logic              sel;
    logic              tx_take;
    logic              tx_full;
    logic              frame_done;
    logic [WORD_W-1:0] tx_word;
    logic [WORD_W-1:0] rx_word;

    assign raw_in = {m_sclk, m_sel_n, m_dio_in};
    assign {sclk_s, sel_n_s, din_s} = synced;

    lsx_sync #(.W(SYNC_W), .RST_VAL(SYNC_RST)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (raw_in),
        .q     (synced)
    );

    lsx_shifter u_shift (
        .clk        (clk),
        .rst_n      (rst_n),
        .sclk_s     (sclk_s),
        .sel_n_s    (sel_n_s),
        .din_s      (din_s),
        .cyc_cfg    (cfg_cycles),
        .lane_cfg   (cfg_lanes),
        .tx_word    (tx_word),
        .tx_full    (tx_full),
        .tx_take    (tx_take),
        .frame_done (frame_done),
        .rx_word    (rx_word),
        .sel        (sel),
        .dout       (m_dio_out),
        .doe        (m_dio_oe)
    );

    lsx_hostregs u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .sel        (sel),
        .tx_wr      (tx_wr),
        .tx_wdata   (tx_wdata),
        .rx_rd      (rx_rd),
        .flag_clr   (flag_clr),
        .irq_en     (irq_en),
        .tx_take    (tx_take),
        .frame_done (frame_done),
        .rx_word    (rx_word),
        .tx_word    (tx_word),
        .tx_full    (tx_full),
        .rx_data    (rx_data),
        .flags      (flags),
        .irq        (irq)
    );
endmodule

// File: tb/lsx_slave_test.sv
// Scoreboard bench: frames are driven by tasks that queue the expected
// received words; a monitor pops and compares whenever rx full is raised.
module lsx_slave_test;
    localparam time HALF = 80ns;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        m_sclk = 1'b0;
    logic        m_sel_n = 1'b1;
    logic [3:0]  m_dio_in = '0;
    logic [3:0]  m_dio_out;
    logic [3:0]  m_dio_oe;
    logic [3:0]  cfg_cycles = '0;
    logic [1:0]  cfg_lanes = '0;
    logic [2:0]  irq_en = '0;
    logic        tx_wr = 1'b0;
    logic [63:0] tx_wdata = '0;
    logic        rx_rd = 1'b0;
    logic [2:0]  flag_clr = '0;
    logic [63:0] rx_data;
    logic [2:0]  flags;
    logic [2:0]  irq;

    int checks = 0;
    int fails = 0;
    logic mon_en = 1'b0;
    logic done = 1'b0;
    logic [63:0] exp_q[$];
    logic [63:0] got;

    always #5ns clk = ~clk;

    lsx_slave uut (.*);

    task automatic check(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic host_write(input logic [63:0] w);
        @(negedge clk);
        tx_wr = 1'b1;
        tx_wdata = w;
        @(negedge clk);
        tx_wr = 1'b0;
    endtask

    task automatic clear_flags(input logic [2:0] m);
        @(negedge clk);
        flag_clr = m;
        @(negedge clk);
        flag_clr = '0;
    endtask

    function automatic int lanes_for(input logic [1:0] code);
        return (code == 2'd0) ? 1 : (code == 2'd1) ? 2 : 4;
    endfunction

    // Master model: mode 0, most significant bits first, stops after stop_at cycles.
    task automatic spi_frame(input logic [63:0] mosi, output logic [63:0] miso, input int stop_at);
        int ln;
        int nb;
        ln = lanes_for(cfg_lanes);
        nb = (int'(cfg_cycles) + 1) * ln;
        miso = '0;
        for (int c = 0; c < stop_at; c++) begin
            for (int l = 0; l < ln; l++) m_dio_in[l] = mosi[nb - (c + 1) * ln + l];
            #(HALF);
            for (int l = 0; l < ln; l++) miso[nb - (c + 1) * ln + l] = m_dio_out[l];
            m_sclk = 1'b1;
            #(HALF);
            m_sclk = 1'b0;
        end
        #(HALF);
    endtask

    task automatic full_frame(input logic [63:0] mosi, output logic [63:0] miso);
        if (mon_en) exp_q.push_back(mosi);
        spi_frame(mosi, miso, int'(cfg_cycles) + 1);
        tick(6);
    endtask

    // Monitor: pop the expected word and read out when rx full appears.
    initial begin
        forever begin
            @(negedge clk);
            if (mon_en && flags[1]) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R7 unexpected word", rx_data, '0);
                end else begin
                    logic [63:0] e;
                    e = exp_q.pop_front();
                    check(rx_data == e, "R7 received word", rx_data, e);
                end
                rx_rd = 1'b1;
                @(negedge clk);
                rx_rd = 1'b0;
            end
        end
    end

    initial begin
        #(10ns * 150000);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        tick(5);
        rst_n = 1'b1;
        tick(3);
        // Reset state.
        check(flags == 3'b001, "R5 reset flags", 64'(flags), 64'h1);
        check(m_dio_oe == 4'h0, "R11 oe off when deselected", 64'(m_dio_oe), 64'h0);
        check(irq == 3'b000, "R10 irq idle", 64'(irq), 64'h0);
        irq_en = 3'b111;
        mon_en = 1'b1;

        // R3 R4 R6: 4 lanes, 8 cycles; write does not start a frame.
        cfg_lanes = 2'd2; cfg_cycles = 4'd7;
        m_sel_n = 1'b0; tick(10);
        host_write(64'hA5C3_0F1E);
        tick(20);
        check(flags[1] == 1'b0, "R3 write starts nothing", 64'(flags), 64'h1);
        check(flags[0] == 1'b1, "R5 tbe after idle load", 64'(flags), 64'h1);
        check(m_dio_oe == 4'hF, "R11 four lanes enabled", 64'(m_dio_oe), 64'hF);
        full_frame(64'h1234_5678, got);
        check(got == 64'hA5C3_0F1E, "R6 quad transmit word", got, 64'hA5C3_0F1E);
        tick(10);
        check(flags[1] == 1'b0, "R7 read clears rx full", 64'(flags), 64'h0);

        // R4 R5 R6: 1 lane, 16 cycles; write mid-frame clears tbe and hands over.
        cfg_lanes = 2'd0; cfg_cycles = 4'd15;
        host_write(64'hBEEF);
        tick(5);
        check(m_dio_oe == 4'h1, "R11 single lane enabled", 64'(m_dio_oe), 64'h1);
        fork
            full_frame(64'h1357, got);
            begin
                tick(40);
                host_write(64'h4D2A);
                tick(3);
                check(flags[0] == 1'b0, "R5 write clears tbe", 64'(flags), 64'h0);
            end
        join
        check(got == 64'hBEEF, "R6 single lane transmit", got, 64'hBEEF);
        check(flags[0] == 1'b1, "R5 tbe after frame-end load", 64'(flags), 64'h1);
        full_frame(64'h8001, got);
        check(got == 64'h4D2A, "R5 handed-over word sent", got, 64'h4D2A);

        // R4: 2 lanes, 5 cycles = 10 bits.
        cfg_lanes = 2'd1; cfg_cycles = 4'd4;
        host_write(64'h2B6);
        tick(5);
        full_frame(64'h1C9, got);
        check(got == 64'h2B6, "R4 dual lane ten bits", got, 64'h2B6);

        // R9: no write, received word goes back out.
        full_frame(64'h0A5, got);
        check(got == 64'h1C9, "R9 recirculated word", got, 64'h1C9);

        // R1: activity while deselected has no effect.
        tick(10);
        m_sel_n = 1'b1; tick(10);
        check(m_dio_oe == 4'h0 && m_dio_out == 4'h0, "R11 lanes off deselected", 64'(m_dio_oe), 64'h0);
        for (int i = 0; i < 5; i++) begin
            m_dio_in = 4'(i * 7 + 3);
            #(HALF); m_sclk = 1'b1; #(HALF); m_sclk = 1'b0;
        end
        host_write(64'h155);
        tick(10);
        check(flags[1] == 1'b0, "R1 no frame while deselected", 64'(flags), 64'h0);
        check(flags[0] == 1'b1, "R1 write ignored deselected", 64'(flags), 64'h1);
        m_sel_n = 1'b0; tick(10);
        full_frame(64'h2F0, got);
        check(got == 64'h0A5, "R1 shift register untouched", got, 64'h0A5);

        // R2: abort after two cycles, then an empty-buffer frame sends zeros.
        host_write(64'h3C3);
        tick(5);
        spi_frame(64'h155, got, 2);
        m_sel_n = 1'b1;
        tick(20);
        check(flags[1] == 1'b0, "R2 no rx full on abort", 64'(flags), 64'h0);
        m_sel_n = 1'b0; tick(10);
        full_frame(64'h111, got);
        check(got == 64'h0, "R2 partial data discarded", got, 64'h0);
        tick(10);

        // R8 R10: two frames without a read.
        mon_en = 1'b0;
        full_frame(64'h0F0, got);
        check(got == 64'h111, "R9 recirculated after abort", got, 64'h111);
        full_frame(64'h30C, got);
        check(got == 64'h0F0, "R9 second recirculation", got, 64'h0F0);
        check(flags[2:1] == 2'b11, "R8 overrun set", 64'(flags), 64'h6);
        check(rx_data == 64'h30C, "R8 rx overwritten", rx_data, 64'h30C);
        check(irq[2] == 1'b1, "R10 overrun irq enabled", 64'(irq), 64'h4);
        irq_en = 3'b011; tick(2);
        check(irq[2] == 1'b0, "R10 overrun irq masked", 64'(irq), 64'h0);
        clear_flags(3'b100); tick(2);
        check(flags[2] == 1'b0, "R10 overrun cleared", 64'(flags), 64'h0);
        clear_flags(3'b001); tick(2);
        check(flags[0] == 1'b0 && irq[0] == 1'b0, "R10 tbe cleared", 64'(flags), 64'h0);
        exp_q.push_back(64'h30C);
        mon_en = 1'b1;
        tick(10);
        check(flags[1] == 1'b0, "R7 rx full cleared by read", 64'(flags), 64'h0);
        check(exp_q.size() == 0, "R7 all words seen", 64'(exp_q.size()), 64'h0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule